// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns single high-level flash requests into the byte-wide bus cycles that a raw NAND device expects. A request names an operation (identify, page read, page program, block erase or status), a page number and a starting column, and is launched with a one-cycle start strobe. The sequencer then drives the command-latch and address-latch enables and the write and read strobes, one bus cycle at a time. Program data comes in on a valid/ready byte stream, and read data, identity bytes and status leave on a second stream.

The sequencer never watches a ready/busy pin. Before each operation, and again after a read start, a program or an erase, it issues the status command and reads the status byte repeatedly, up to a bounded number of tries, until the ready bit is set. Requests whose alignment is wrong are refused before any bus cycle is issued. At the end the block reports completion, device-reported failure or retry exhaustion.

Top module: `nand_seq`

## Requirements
- R1: After reset both strobes are high, both latch enables are low, the data bus is not driven, `busy` is low and the done, fail, timeout and reject outputs are low.
- R2: Every bus cycle holds its strobe low for exactly STROBE_CLKS clocks. The latch enables are set at least one clock before the strobe falls and stay unchanged until at least one clock after it rises. Command and address latch are never high together, and the two strobes are never low together.
- R3: Every request other than status starts with the command 0x70 and then reads status bytes until one has bit 6 (0x40, ready) set. Bit 5 is ignored, so a byte of 0xA0 counts as not ready.
- R4: Page read issues 0x00, then five address bytes (column low, column high, page bits 7:0, 15:8, 23:16), then 0x30. It then polls status after 0x70, issues 0x00 again, and streams PAGE_BYTES+SPARE_BYTES-column bytes in device order.
- R5: Page program issues 0x80, then address bytes 0x00, 0x00 and the three page bytes from low to high. It then writes PAGE_BYTES+SPARE_BYTES bytes taken in order from the write stream, issues 0x10, and polls status after 0x70.
- R6: Block erase issues 0x60, then exactly three address bytes (page low to high), then 0xD0, and polls status after 0x70.
- R7: Identify issues 0x90 and one address byte of 0x00, then returns four bytes read from the device on the read stream.
- R8: Status issues 0x70 without a pre-poll and returns the single byte read on the read stream.
- R9: If POLL_MAX consecutive status reads in one poll all lack the ready bit, the request ends with `op_timeout` set and no further bus cycle is issued. A ready bit on read number POLL_MAX still completes normally.
- R10: After program or erase, bit 0 of the final ready status byte sets `op_fail`. `op_fail`, `op_timeout` and `op_reject` hold until the next accepted start.
- R11: These requests are refused with `op_reject` and `op_done` and produce no bus cycle: an erase whose page number is not a multiple of PAGES_PER_BLOCK, a program whose column is not 0, and an opcode above 4 (opcodes: 0 identify, 1 read, 2 program, 3 erase, 4 status).
- R12: A start strobe while `busy` is high is ignored.
- R13: Each accepted start produces exactly one single-cycle `op_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start strobe for a request |
| req_op | input | 3 | Operation code |
| req_page | input | 24 | Page number |
| req_col | input | 16 | Starting column |
| busy | output | 1 | Request in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_fail | output | 1 | Device reported program/erase failure |
| op_timeout | output | 1 | Ready never seen within the retry limit |
| op_reject | output | 1 | Request refused for alignment or opcode |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Program data byte accepted |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte valid |
| rd_ready | input | 1 | Consumer accepts read byte |
| rd_data | output | 8 | Read data byte |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven to the device |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte returned by the device |

## Verification
The assertions assume that the read column is below PAGE_BYTES+SPARE_BYTES, that PAGES_PER_BLOCK is a power of two, and that the device keeps `nf_dq_in` steady while the read strobe is low. The bench device model changes its returned byte only on the falling clock edge after a strobe has risen. It uses only in-range columns and offers program data only through the stream handshake. The consumer stalls `rd_ready` on a fixed pattern so that stream back-pressure is always legal.

// File: rtl/nand_seq_pkg.sv
// Shared types and codes for the NAND sequencer.
// Assumes an 8-bit device bus and the command set listed below.
package nand_seq_pkg;
    typedef enum logic [2:0] {
        OP_IDENT  = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_STATUS = 3'd4
    } op_e;

    // lane code decides which latch the byte goes to
    typedef enum logic [1:0] {
        LANE_DATA = 2'd0,
        LANE_CMD  = 2'd1,
        LANE_ADDR = 2'd2
    } lane_e;

    localparam logic [7:0] C_READ     = 8'h00;
    localparam logic [7:0] C_READ_GO  = 8'h30;
    localparam logic [7:0] C_PROG     = 8'h80;
    localparam logic [7:0] C_PROG_GO  = 8'h10;
    localparam logic [7:0] C_ERASE    = 8'h60;
    localparam logic [7:0] C_ERASE_GO = 8'hD0;
    localparam logic [7:0] C_STATUS   = 8'h70;
    localparam logic [7:0] C_IDENT    = 8'h90;

    localparam int SB_FAIL  = 0;
    localparam int SB_READY = 6;
endpackage

// File: rtl/nand_bus_phy.sv
// Runs one device bus cycle per go: one setup clock with the latch
// enables set, STROBE_CLKS clocks with the strobe low, one hold clock.
// Assumes go is only raised while idle is high.
module nand_bus_phy
    import nand_seq_pkg::*;
#(
    parameter int STROBE_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  lane_e      lane,
    input  logic       is_rd,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic       idle,
    output logic       ack,
    output logic [7:0] rbyte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    localparam int CW = $clog2(STROBE_CLKS + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} ph_e;
    ph_e          ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    assign idle = (ph == PH_IDLE);

    // bus cycle phase machine with registered pin outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE; cnt <= '0; rd_q <= 1'b0; ack <= 1'b0;
            rbyte <= '0; cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1;
            re_n <= 1'b1; dq_out <= '0; dq_oe <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (ph)
                PH_IDLE: if (go) begin
                    cle    <= (lane == LANE_CMD);
                    ale    <= (lane == LANE_ADDR);
                    dq_out <= wbyte;
                    dq_oe  <= !is_rd;
                    rd_q   <= is_rd;
                    ph     <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (rd_q) re_n <= 1'b0;
                    else      we_n <= 1'b0;
                    cnt <= '0;
                    ph  <= PH_STROBE;
                end
                PH_STROBE: begin
                    if (cnt == CW'(STROBE_CLKS - 1)) begin
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (rd_q) rbyte <= dq_in;
                        ph <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cle <= 1'b0; ale <= 1'b0; dq_oe <= 1'b0;
                    ack <= 1'b1;
                    ph  <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_poll_ctr.sv
// Counts status reads inside one poll; last flags the final allowed try.
// Assumes clr is raised when the status command of a poll completes.
module nand_poll_ctr #(
    parameter int POLL_MAX = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int PW = $clog2(POLL_MAX + 1);
    logic [PW-1:0] n;

    assign last = (n == PW'(POLL_MAX - 1));

    // retry count, restarted for each poll
    always_ff @(posedge clk) begin
        if (!rst_n || clr) n <= '0;
        else if (tick)     n <= n + 1'b1;
    end
endmodule

// File: rtl/nand_addr_mux.sv
// Picks the address byte for index idx of the current request and flags
// the last one: five bytes for read/program, three row bytes for erase,
// a single zero byte for identify.
module nand_addr_mux
    import nand_seq_pkg::*;
(
    input  op_e         op,
    input  logic [23:0] page,
    input  logic [15:0] col,
    input  logic [2:0]  idx,
    output logic [7:0]  abyte,
    output logic        last
);
    logic [39:0] full;
    assign full = {page, col};

    // byte select per operation
    always_comb begin
        case (op)
            OP_IDENT: begin abyte = 8'h00;              last = 1'b1; end
            OP_ERASE: begin abyte = page[idx[1:0]*8 +: 8]; last = (idx == 3'd2); end
            default:  begin abyte = full[idx*8 +: 8];   last = (idx == 3'd4); end
        endcase
    end
endmodule

// File: rtl/nand_seq.sv
// Request-level NAND sequencer: pre-poll, command, address, data and
// post-poll steps issued through one bus-cycle engine.
// Assumes read column < PAGE_BYTES+SPARE_BYTES and PAGES_PER_BLOCK is 2**k.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES      = 2048,
    parameter int SPARE_BYTES     = 64,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int STROBE_CLKS     = 2,
    parameter int POLL_MAX        = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic [2:0]  req_op,
    input  logic [23:0] req_page,
    input  logic [15:0] req_col,
    output logic        busy,
    output logic        op_done,
    output logic        op_fail,
    output logic        op_timeout,
    output logic        op_reject,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [7:0]  rd_data,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_out,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_in
);
    localparam int TOTAL = PAGE_BYTES + SPARE_BYTES;
    localparam int CNT_W = $clog2(TOTAL + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_CMD, S_PRE_POLL, S_CMD1, S_ADDR, S_WDATA,
        S_CMD2, S_POST_CMD, S_POST_POLL, S_RDCMD, S_RDATA
    } st_e;

    st_e              st;
    op_e              op_q;
    logic [23:0]      page_q;
    logic [15:0]      col_q;
    logic [2:0]       aidx;
    logic [CNT_W-1:0] bcnt, btarget;
    logic             pending;

    logic       go, gate, ph_idle, ph_ack, cyc_rd, poll_last, a_last;
    lane_e      cyc_lane;
    logic [7:0] cyc_byte, rbyte, abyte, cmd1, cmd2;
    logic       misalign;

    nand_bus_phy #(.STROBE_CLKS(STROBE_CLKS)) i_phy (
        .clk(clk), .rst_n(rst_n), .go(go), .lane(cyc_lane), .is_rd(cyc_rd),
        .wbyte(cyc_byte), .dq_in(nf_dq_in), .idle(ph_idle), .ack(ph_ack),
        .rbyte(rbyte), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
        .re_n(nf_re_n), .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
    );

    nand_poll_ctr #(.POLL_MAX(POLL_MAX)) i_poll (
        .clk(clk), .rst_n(rst_n),
        .clr(ph_ack && (st == S_PRE_CMD || st == S_POST_CMD)),
        .tick(ph_ack && (st == S_PRE_POLL || st == S_POST_POLL)),
        .last(poll_last)
    );

    nand_addr_mux i_amux (
        .op(op_q), .page(page_q), .col(col_q), .idx(aidx),
        .abyte(abyte), .last(a_last)
    );

    // refusal rules checked on the incoming request
    always_comb begin
        case (req_op)
            3'd2:    misalign = (req_col != 16'd0);
            3'd3:    misalign = ((req_page & 24'(PAGES_PER_BLOCK - 1)) != 24'd0);
            3'd0, 3'd1, 3'd4: misalign = 1'b0;
            default: misalign = 1'b1;
        endcase
    end

    // first and closing command byte of each operation
    always_comb begin
        case (op_q)
            OP_IDENT: cmd1 = C_IDENT;
            OP_READ:  cmd1 = C_READ;
            OP_PROG:  cmd1 = C_PROG;
            OP_ERASE: cmd1 = C_ERASE;
            default:  cmd1 = C_STATUS;
        endcase
        case (op_q)
            OP_READ: cmd2 = C_READ_GO;
            OP_PROG: cmd2 = C_PROG_GO;
            default: cmd2 = C_ERASE_GO;
        endcase
    end

    // bus cycle requested by the current step
    always_comb begin
        cyc_lane = LANE_DATA; cyc_rd = 1'b0; cyc_byte = 8'h00; gate = 1'b1;
        case (st)
            S_PRE_CMD, S_POST_CMD: begin cyc_lane = LANE_CMD; cyc_byte = C_STATUS; end
            S_PRE_POLL, S_POST_POLL: cyc_rd = 1'b1;
            S_CMD1:  begin cyc_lane = LANE_CMD;  cyc_byte = cmd1; end
            S_ADDR:  begin cyc_lane = LANE_ADDR; cyc_byte = abyte; end
            S_WDATA: begin cyc_byte = wr_data; gate = wr_valid; end
            S_CMD2:  begin cyc_lane = LANE_CMD;  cyc_byte = cmd2; end
            S_RDCMD: begin cyc_lane = LANE_CMD;  cyc_byte = C_READ; end
            S_RDATA: begin cyc_rd = 1'b1; gate = !rd_valid; end
            default: ;
        endcase
    end

    assign go       = (st != S_IDLE) && ph_idle && !pending && gate;
    assign wr_ready = go && (st == S_WDATA);
    assign busy     = (st != S_IDLE);

    // request sequencing, result flags and read stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; op_q <= OP_STATUS; page_q <= '0; col_q <= '0;
            aidx <= '0; bcnt <= '0; btarget <= '0; pending <= 1'b0;
            op_done <= 1'b0; op_fail <= 1'b0; op_timeout <= 1'b0;
            op_reject <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
        end else begin
            op_done <= 1'b0;
            if (rd_valid && rd_ready) rd_valid <= 1'b0;
            if (go) pending <= 1'b1;
            else if (ph_ack) pending <= 1'b0;

            if (st == S_IDLE) begin
                if (req_start) begin
                    op_fail <= 1'b0; op_timeout <= 1'b0; op_reject <= 1'b0;
                    if (misalign) begin
                        op_reject <= 1'b1;
                        op_done   <= 1'b1;
                    end else begin
                        op_q <= op_e'(req_op); page_q <= req_page; col_q <= req_col;
                        aidx <= '0; bcnt <= '0;
                        case (req_op)
                            3'd0:    btarget <= CNT_W'(4);
                            3'd1:    btarget <= CNT_W'(TOTAL) - CNT_W'(req_col);
                            default: btarget <= CNT_W'(1);
                        endcase
                        st <= (req_op == 3'd4) ? S_CMD1 : S_PRE_CMD;
                    end
                end
            end else if (ph_ack) begin
                case (st)
                    S_PRE_CMD:  st <= S_PRE_POLL;
                    S_POST_CMD: st <= S_POST_POLL;
                    S_PRE_POLL, S_POST_POLL: begin
                        if (rbyte[SB_READY]) begin
                            if (st == S_PRE_POLL)   st <= S_CMD1;
                            else if (op_q == OP_READ) st <= S_RDCMD;
                            else begin
                                op_fail <= rbyte[SB_FAIL];
                                op_done <= 1'b1;
                                st      <= S_IDLE;
                            end
                        end else if (poll_last) begin
                            op_timeout <= 1'b1;
                            op_done    <= 1'b1;
                            st         <= S_IDLE;
                        end
                    end
                    S_CMD1: st <= (op_q == OP_STATUS) ? S_RDATA : S_ADDR;
                    S_ADDR: begin
                        aidx <= aidx + 1'b1;
                        if (a_last) begin
                            if (op_q == OP_IDENT)     st <= S_RDATA;
                            else if (op_q == OP_PROG) st <= S_WDATA;
                            else                      st <= S_CMD2;
                        end
                    end
                    S_WDATA: begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == CNT_W'(TOTAL - 1)) st <= S_CMD2;
                    end
                    S_CMD2:  st <= S_POST_CMD;
                    S_RDCMD: st <= S_RDATA;
                    S_RDATA: begin
                        rd_valid <= 1'b1;
                        rd_data  <= rbyte;
                        bcnt     <= bcnt + 1'b1;
                        if (bcnt == btarget - 1'b1) begin
                            op_done <= 1'b1;
                            st      <= S_IDLE;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nand_seq_chk.sv
// Protocol checker bound to nand_seq; watches pins and result flags only.
module nand_seq_chk #(
    parameter int STROBE_CLKS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic busy,
    input logic op_done,
    input logic op_timeout,
    input logic op_reject
);
    logic [7:0] low_run;

    // length of the current strobe-low run
    always_ff @(posedge clk) begin
        if (!rst_n)                low_run <= '0;
        else if (!we_n || !re_n)   low_run <= (low_run == 8'hFF) ? low_run : low_run + 1'b1;
        else                       low_run <= '0;
    end

    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_latch_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> $stable(cle) && $stable(ale));
    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) || $rose(re_n)) |-> low_run == 8'(STROBE_CLKS));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> we_n && re_n);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    assert_reject_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_reject) |-> !$past(busy));
    assert_timeout_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_timeout |-> !busy || !$past(op_timeout));
endmodule

bind nand_seq nand_seq_chk #(.STROBE_CLKS(STROBE_CLKS)) i_nand_seq_chk (
    .clk(clk), .rst_n(rst_n), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
    .re_n(nf_re_n), .busy(busy), .op_done(op_done), .op_timeout(op_timeout),
    .op_reject(op_reject)
);

// File: tb/test_nand_seq.sv
module test_nand_seq;
    localparam int PB = 16, SB = 4, TOT = PB + SB, STRB = 2, PMAX = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [2:0] req_op = '0;
    logic [23:0] req_page = '0;
    logic [15:0] req_col = '0;
    logic busy, op_done, op_fail, op_timeout, op_reject;
    logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b1;
    logic [7:0] wr_data = '0, rd_data;
    logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_out, nf_dq_in;

    always #10 clk = ~clk;

    nand_seq #(.PAGE_BYTES(PB), .SPARE_BYTES(SB), .PAGES_PER_BLOCK(64),
               .STROBE_CLKS(STRB), .POLL_MAX(PMAX)) i_nand_seq (.*);

    int total = 0, bad = 0, done_cnt = 0;
    logic [9:0] exp_ev[$];
    logic [7:0] exp_rd[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wpat(input int i);
        return 8'(i * 13 + 7);
    endfunction

    // ---- device model and bus monitor (all on the falling edge) ----
    typedef enum {M_STS, M_ID, M_DATA} mode_e;
    mode_e mode = M_STS;
    int busy_left = 0, busy_set = 0, id_idx = 0, aidx = 0, col = 0, lowcnt = 0;
    logic [7:0] abuf[8];
    logic [7:0] pg = '0;
    logic fail_bit = 1'b0, fail_next = 1'b0, pwe = 1'b1, pre = 1'b1;
    logic [9:0] ev, e;

    always_comb begin
        case (mode)
            M_STS:   nf_dq_in = (busy_left != 0) ? 8'hA0 : (8'hC0 | {7'd0, fail_bit});
            M_ID:    case (id_idx) 0: nf_dq_in = 8'hAD; 1: nf_dq_in = 8'hDC;
                                   2: nf_dq_in = 8'h10; default: nf_dq_in = 8'h95; endcase
            default: nf_dq_in = 8'(col * 3) + pg;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (op_done) done_cnt++;
            chk(!(nf_cle && nf_ale) && !(!nf_we_n && !nf_re_n), "R2 latch/strobe overlap",
                {nf_cle, nf_ale, nf_we_n, nf_re_n}, 0);
            if (!nf_we_n || !nf_re_n) lowcnt++;
            else if (lowcnt != 0) begin
                chk(lowcnt == STRB, "R2 strobe width", lowcnt, STRB);
                lowcnt = 0;
            end
            if (nf_we_n && !pwe) begin
                ev = {nf_cle ? 2'd1 : nf_ale ? 2'd2 : 2'd0, nf_dq_out};
                if (exp_ev.size() == 0) chk(1'b0, "R3 unexpected bus write", ev, 0);
                else begin
                    e = exp_ev.pop_front();
                    chk(ev == e, "R4/R5/R6 bus write order", ev, e);
                end
                if (nf_cle) begin
                    aidx = 0;
                    case (nf_dq_out)
                        8'h70: mode = M_STS;
                        8'h90: begin mode = M_ID; id_idx = 0; end
                        8'h00: begin mode = M_DATA; fail_bit = 1'b0; end
                        8'h30: begin col = {abuf[1], abuf[0]}; pg = abuf[2]; busy_left = busy_set; end
                        8'h10: begin busy_left = busy_set; fail_bit = fail_next; end
                        8'hD0: busy_left = busy_set;
                        8'h80, 8'h60: fail_bit = 1'b0;
                        default: ;
                    endcase
                end else if (nf_ale) begin
                    abuf[aidx[2:0]] = nf_dq_out;
                    aidx++;
                end
            end
            if (nf_re_n && !pre) begin
                case (mode)
                    M_STS:  if (busy_left > 0) busy_left--;
                    M_ID:   id_idx++;
                    default: col++;
                endcase
            end
            pwe = nf_we_n; pre = nf_re_n;
        end
    end

    // scoreboard monitor for the read stream
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (exp_rd.size() == 0) chk(1'b0, "R4/R7/R8 unexpected read byte", rd_data, 0);
            else begin
                e[7:0] = exp_rd.pop_front();
                chk(rd_data == e[7:0], "R4/R7/R8 read byte", rd_data, e[7:0]);
            end
        end
    end

    // consumer back-pressure and program data source
    initial begin
        int k = 0;
        int widx = 0;
        bit took = 0;
        forever begin
            @(negedge clk);
            k++;
            rd_ready = (k % 3) != 2;
            if (!busy) widx = 0;
            else if (took) widx++;
            wr_data = wpat(widx);
            wr_valid = 1'b1;
            took = wr_valid && wr_ready;
        end
    end

    // ---- driver helpers ----
    task automatic pev(input logic [1:0] t, input logic [7:0] b);
        exp_ev.push_back({t, b});
    endtask

    task automatic run(input logic [2:0] op, input logic [23:0] page, input logic [15:0] col_i,
                       input bit xf, input bit xt, input bit xr, input string tag);
        int d0 = done_cnt;
        @(negedge clk);
        req_op = op; req_page = page; req_col = col_i; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(done_cnt == d0 + 1, {tag, " R13 one done"}, done_cnt - d0, 1);
        chk(op_fail == xf, {tag, " R10 fail"}, op_fail, xf);
        chk(op_timeout == xt, {tag, " R9 timeout"}, op_timeout, xt);
        chk(op_reject == xr, {tag, " R11 reject"}, op_reject, xr);
        chk(exp_ev.size() == 0, {tag, " bus writes left"}, exp_ev.size(), 0);
        chk(exp_rd.size() == 0, {tag, " read bytes left"}, exp_rd.size(), 0);
        exp_ev.delete(); exp_rd.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R13 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe} == 5'b11000, "R1 pins", {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 5'b11000);
        chk({busy, op_done, op_fail, op_timeout, op_reject} == 5'b0, "R1 flags", {busy, op_done, op_fail, op_timeout, op_reject}, 0);

        // R8 status: no pre-poll
        pev(1, 8'h70); exp_rd.push_back(8'hC0);
        run(3'd4, 24'h0, 16'h0, 0, 0, 0, "R8 status");

        // R7 identify
        pev(1, 8'h70); pev(1, 8'h90); pev(2, 8'h00);
        exp_rd.push_back(8'hAD); exp_rd.push_back(8'hDC);
        exp_rd.push_back(8'h10); exp_rd.push_back(8'h95);
        run(3'd0, 24'h0, 16'h0, 0, 0, 0, "R7 ident");

        // R6 erase, R3 polls through 0xA0 bytes
        busy_set = 3;
        pev(1, 8'h70); pev(1, 8'h60); pev(2, 8'h40); pev(2, 8'h01); pev(2, 8'h00);
        pev(1, 8'hD0); pev(1, 8'h70);
        run(3'd3, 24'h000140, 16'h0, 0, 0, 0, "R6 erase");

        // R5 program
        busy_set = 2;
        pev(1, 8'h70); pev(1, 8'h80); pev(2, 8'h00); pev(2, 8'h00);
        pev(2, 8'h0C); pev(2, 8'h0B); pev(2, 8'h0A);
        for (int i = 0; i < TOT; i++) pev(0, wpat(i));
        pev(1, 8'h10); pev(1, 8'h70);
        run(3'd2, 24'h0A0B0C, 16'h0, 0, 0, 0, "R5 program");

        // R4 read from columns 0, 5 and the last one
        foreach (abuf[i]) abuf[i] = '0;
        for (int c = 0; c < TOT; c += (c == 0) ? 5 : (c == 5 ? 14 : 100)) begin
            busy_set = 1;
            pev(1, 8'h70); pev(1, 8'h00); pev(2, 8'(c)); pev(2, 8'h00);
            pev(2, 8'h56); pev(2, 8'h34); pev(2, 8'h12); pev(1, 8'h30);
            pev(1, 8'h70); pev(1, 8'h00);
            for (int j = c; j < TOT; j++) exp_rd.push_back(8'(j * 3) + 8'h56);
            run(3'd1, 24'h123456, 16'(c), 0, 0, 0, "R4 read");
        end

        // R9 retry limit exhausted, then just inside the limit
        busy_set = PMAX;
        pev(1, 8'h70); pev(1, 8'h60); pev(2, 8'h80); pev(2, 8'h00); pev(2, 8'h00);
        pev(1, 8'hD0); pev(1, 8'h70);
        run(3'd3, 24'h000080, 16'h0, 0, 1, 0, "R9 timeout");
        busy_set = PMAX - 1;
        pev(1, 8'h70); pev(1, 8'h60); pev(2, 8'hC0); pev(2, 8'h00); pev(2, 8'h00);
        pev(1, 8'hD0); pev(1, 8'h70);
        run(3'd3, 24'h0000C0, 16'h0, 0, 0, 0, "R9 last try");

        // R10 program failure held, then cleared by the next start
        busy_set = 0; fail_next = 1'b1;
        pev(1, 8'h70); pev(1, 8'h80); pev(2, 8'h00); pev(2, 8'h00);
        pev(2, 8'h01); pev(2, 8'h00); pev(2, 8'h00);
        for (int i = 0; i < TOT; i++) pev(0, wpat(i));
        pev(1, 8'h10); pev(1, 8'h70);
        run(3'd2, 24'h000001, 16'h0, 1, 0, 0, "R10 prog fail");
        fail_next = 1'b0;
        repeat (20) @(negedge clk);
        chk(op_fail == 1'b1, "R10 fail held", op_fail, 1);
        pev(1, 8'h70); exp_rd.push_back(8'hC1);
        run(3'd4, 24'h0, 16'h0, 0, 0, 0, "R10 clear on start");

        // R11 refusals: no bus writes expected
        run(3'd3, 24'h000041, 16'h0, 0, 0, 1, "R11 erase misaligned");
        run(3'd2, 24'h000002, 16'h3, 0, 0, 1, "R11 program column");
        run(3'd7, 24'h0, 16'h0, 0, 0, 1, "R11 bad opcode");

        // R12 start while busy is ignored
        busy_set = 2;
        pev(1, 8'h70); pev(1, 8'h60); pev(2, 8'h00); pev(2, 8'h01); pev(2, 8'h00);
        pev(1, 8'hD0); pev(1, 8'h70);
        fork
            run(3'd3, 24'h000100, 16'h0, 0, 0, 0, "R12 busy start");
            begin
                repeat (8) @(negedge clk);
                chk(busy == 1'b1, "R12 busy during erase", busy, 1);
                req_op = 3'd0; req_start = 1'b1;
                @(negedge clk);
                req_start = 1'b0; req_op = 3'd3;
            end
        join

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule